// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Codec

This block protects a data byte with a Hamming code whose check bits sit at the power-of-two positions of the codeword. The encoder half takes a data word and returns its protected codeword. The decoder half takes a codeword that may be damaged. It recomputes each parity group and combines the failing groups into a syndrome. The syndrome is the 1-based position of a single flipped bit. The decoder flips that bit back and returns the data, an error flag, an uncorrectable flag and the reported position.

The two halves are independent and run side by side. Every result is registered, so a value applied to an input appears on the matching output one clock later. A build parameter appends an overall parity bit above the Hamming positions. With that bit the code also detects, without correcting, any double-bit error. Codeword bit k of every port carries codeword position k+1, so bit 0 is position 1.

Top module: `ham_codec`

## Requirements
- R1: Data bits are placed most-significant first into the non-power-of-two positions: data bit 7 goes to position 3, then bits 6..0 go to positions 5, 6, 7, 9, 10, 11 and 12. Codeword port bit k holds position k+1.
- R2: The bit at position 2^j sets even parity over every position whose index has bit j set. For example, data 0x41 encodes to 0x891 and data 0xA5 encodes to 0xA27.
- R3: All outputs are registered. A value driven on an input is reflected on the outputs after exactly one rising clock edge, and not before it.
- R4: A synchronous active-high reset clears the codeword, data, both flags and the position output to zero, whatever the inputs are.
- R5: A valid codeword decodes to its data, with the error flag at 0, the uncorrectable flag at 0 and the position at 0.
- R6: A single flipped data-position bit is repaired. The data output is the original data, the error flag is 1, the uncorrectable flag is 0, and the position equals the flipped position.
- R7: A single flipped check bit (position 1, 2, 4 or 8) sets the error flag and reports that position, with the uncorrectable flag at 0 and the data output unchanged.
- R8: A nonzero syndrome above the highest codeword position (13 to 15 at the default width) sets both the error and uncorrectable flags. The position output reports the syndrome, and the data bits are taken from the codeword without any flip.
- R9: With the overall-parity option enabled, codeword bit 12 (position 13) makes the count of ones over all 13 bits even. A flip of that bit alone sets the error flag, reports position 13 and leaves the data intact. A flip at a Hamming position is still repaired as in R6 and R7.
- R10: With the overall-parity option enabled, a nonzero syndrome with even overall parity is a double error. It sets both flags, reports the syndrome as the position and passes the data bits through unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| enc_data_i | input | DATA_W (8) | Data word to encode |
| enc_cw_o | output | CW_W (12, or 13 with overall parity) | Registered codeword, bit k = position k+1 |
| dec_cw_i | input | CW_W | Codeword to check and repair |
| dec_data_o | output | DATA_W | Registered repaired data |
| dec_err_o | output | 1 | Any error was seen in the last decoded word |
| dec_unc_o | output | 1 | The last error could not be corrected |
| dec_pos_o | output | POS_W (4) | Reported error position, 0 when clean |

## Verification
Each encoder and decoder result is due one rising edge after its input changes. The bench drives inputs on the falling edge and reads all outputs on the next falling edge, which comes right after the single register stage. One probe reads the outputs just before that edge to confirm the old value still holds. Reset is checked the same way, one edge after it is raised, with nonzero inputs applied.

// File: rtl/ham_pkg.sv
package ham_pkg;

    typedef enum logic [1:0] {
        FIX_NONE = 2'd0,
        FIX_DONE = 2'd1,
        FIX_FAIL = 2'd2
    } fix_kind_e;

    // smallest number of check bits that covers dw data bits
    function automatic int chk_count(int dw);
        for (int r = 1; r < 16; r++) begin
            if ((1 << r) >= dw + r + 1) return r;
        end
        return 16;
    endfunction

    function automatic bit is_pow2(int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // 0-based ordinal of the non-power-of-two position p
    function automatic int data_ord(int p);
        int pw;
        pw = 0;
        for (int q = 1; q <= p; q++) begin
            if (is_pow2(q)) pw++;
        end
        return p - 1 - pw;
    endfunction

    // position (1-based) holding the ord-th data slot
    function automatic int slot_pos(int ord);
        int seen;
        seen = 0;
        for (int p = 1; p < 64; p++) begin
            if (!is_pow2(p)) begin
                if (seen == ord) return p;
                seen++;
            end
        end
        return 1;
    endfunction

    // bit p-1 set when position p falls in check group j
    function automatic logic [63:0] cover_mask(int j);
        logic [63:0] m;
        m = '0;
        for (int p = 1; p <= 64; p++) begin
            if (((p >> j) & 1) != 0) m[p-1] = 1'b1;
        end
        return m;
    endfunction

    function automatic int pos_width(int cw, int chk);
        int w;
        w = $clog2(cw + 1);
        return (w > chk) ? w : chk;
    endfunction

endpackage

// File: rtl/ham_enc.sv
module ham_enc
    import ham_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter bit DED_EN = 1'b0,
    localparam int CHK_W = chk_count(DATA_W),
    localparam int HAM_W = DATA_W + CHK_W,
    localparam int CW_W  = HAM_W + (DED_EN ? 1 : 0)
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);

    logic [HAM_W-1:0] body;
    logic [HAM_W-1:0] full;

    for (genvar p = 1; p <= HAM_W; p++) begin : g_place
        if (is_pow2(p)) begin : g_chk
            localparam logic [63:0] MASK = cover_mask($clog2(p));
            assign body[p-1] = 1'b0;
            assign full[p-1] = ^(body & MASK[HAM_W-1:0]);
        end else begin : g_dat
            assign body[p-1] = data_i[DATA_W-1-data_ord(p)];
            assign full[p-1] = body[p-1];
        end
    end

    if (DED_EN) begin : g_ded
        assign cw_o = {^full, full};
    end else begin : g_sec
        assign cw_o = full;
    end

endmodule

// File: rtl/ham_syndrome.sv
module ham_syndrome
    import ham_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter bit DED_EN = 1'b0,
    localparam int CHK_W = chk_count(DATA_W),
    localparam int HAM_W = DATA_W + CHK_W,
    localparam int CW_W  = HAM_W + (DED_EN ? 1 : 0)
) (
    input  logic [CW_W-1:0]  cw_i,
    output logic [CHK_W-1:0] syn_o,
    output logic             par_bad_o
);

    for (genvar j = 0; j < CHK_W; j++) begin : g_grp
        localparam logic [63:0] MASK = cover_mask(j);
        assign syn_o[j] = ^(cw_i[HAM_W-1:0] & MASK[HAM_W-1:0]);
    end

    if (DED_EN) begin : g_ded
        assign par_bad_o = ^cw_i;
    end else begin : g_sec
        assign par_bad_o = 1'b0;
    end

endmodule

// File: rtl/ham_correct.sv
module ham_correct
    import ham_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter bit DED_EN = 1'b0,
    localparam int CHK_W = chk_count(DATA_W),
    localparam int HAM_W = DATA_W + CHK_W,
    localparam int CW_W  = HAM_W + (DED_EN ? 1 : 0),
    localparam int POS_W = pos_width(CW_W, CHK_W)
) (
    input  logic [HAM_W-1:0]  ham_i,
    input  logic [CHK_W-1:0]  syn_i,
    input  logic              par_bad_i,
    output logic [DATA_W-1:0] data_o,
    output fix_kind_e         kind_o,
    output logic [POS_W-1:0]  pos_o
);

    logic             flip_en;
    logic [HAM_W-1:0] fixed;

    always_comb begin
        kind_o  = FIX_NONE;
        pos_o   = '0;
        flip_en = 1'b0;
        if (syn_i != '0) begin
            pos_o = POS_W'(syn_i);
            if (DED_EN && !par_bad_i) begin
                kind_o = FIX_FAIL;
            end else if (int'(syn_i) > HAM_W) begin
                kind_o = FIX_FAIL;
            end else begin
                kind_o  = FIX_DONE;
                flip_en = 1'b1;
            end
        end else if (DED_EN && par_bad_i) begin
            kind_o = FIX_DONE;
            pos_o  = POS_W'(CW_W);
        end
    end

    for (genvar p = 1; p <= HAM_W; p++) begin : g_flip
        assign fixed[p-1] = ham_i[p-1] ^ (flip_en && (syn_i == CHK_W'(p)));
    end

    for (genvar k = 0; k < DATA_W; k++) begin : g_pick
        assign data_o[k] = fixed[slot_pos(DATA_W-1-k)-1];
    end

endmodule

// File: rtl/ham_codec.sv
module ham_codec
    import ham_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter bit DED_EN = 1'b0,
    localparam int CHK_W = chk_count(DATA_W),
    localparam int HAM_W = DATA_W + CHK_W,
    localparam int CW_W  = HAM_W + (DED_EN ? 1 : 0),
    localparam int POS_W = pos_width(CW_W, CHK_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CW_W-1:0]   enc_cw_o,
    input  logic [CW_W-1:0]   dec_cw_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_err_o,
    output logic              dec_unc_o,
    output logic [POS_W-1:0]  dec_pos_o
);

    logic [CW_W-1:0]   enc_cw;
    logic [CHK_W-1:0]  syn;
    logic              par_bad;
    logic [DATA_W-1:0] fix_data;
    fix_kind_e         fix_kind;
    logic [POS_W-1:0]  fix_pos;

    ham_enc #(.DATA_W(DATA_W), .DED_EN(DED_EN)) u_enc (
        .data_i (enc_data_i),
        .cw_o   (enc_cw)
    );

    ham_syndrome #(.DATA_W(DATA_W), .DED_EN(DED_EN)) u_syn (
        .cw_i      (dec_cw_i),
        .syn_o     (syn),
        .par_bad_o (par_bad)
    );

    ham_correct #(.DATA_W(DATA_W), .DED_EN(DED_EN)) u_fix (
        .ham_i     (dec_cw_i[HAM_W-1:0]),
        .syn_i     (syn),
        .par_bad_i (par_bad),
        .data_o    (fix_data),
        .kind_o    (fix_kind),
        .pos_o     (fix_pos)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_cw_o   <= '0;
            dec_data_o <= '0;
            dec_err_o  <= 1'b0;
            dec_unc_o  <= 1'b0;
            dec_pos_o  <= '0;
        end else begin
            enc_cw_o   <= enc_cw;
            dec_data_o <= fix_data;
            dec_err_o  <= (fix_kind != FIX_NONE);
            dec_unc_o  <= (fix_kind == FIX_FAIL);
            dec_pos_o  <= fix_pos;
        end
    end

    // ---------------- checks ----------------
    logic             hist_ok;
    logic [CHK_W-1:0] chk_syn;
    logic             chk_par;
    logic [CW_W-1:0]  recoded;

    always_ff @(posedge clk) begin
        if (rst) hist_ok <= 1'b0;
        else     hist_ok <= 1'b1;
    end

    ham_syndrome #(.DATA_W(DATA_W), .DED_EN(DED_EN)) u_chk_syn (
        .cw_i      (enc_cw_o),
        .syn_o     (chk_syn),
        .par_bad_o (chk_par)
    );

    ham_enc #(.DATA_W(DATA_W), .DED_EN(DED_EN)) u_chk_enc (
        .data_i (dec_data_o),
        .cw_o   (recoded)
    );

    // R2
    enc_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_syn == '0) && !chk_par);

    // R6
    corr_dist_chk: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && !dec_unc_o) |-> ($countones(recoded ^ $past(dec_cw_i)) <= 1));

    // R8
    unc_err_chk: assert property (@(posedge clk) disable iff (rst)
        dec_unc_o |-> dec_err_o);

    // R5
    clean_pos_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_err_o |-> (dec_pos_o == '0));

endmodule

// File: tb/ham_codec_tb_top.sv
module ham_codec_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    // single-error-correcting instance
    logic [7:0]  s_din;
    logic [11:0] s_enc;
    logic [11:0] s_cw;
    logic [7:0]  s_dout;
    logic        s_err, s_unc;
    logic [3:0]  s_pos;

    ham_codec #(.DATA_W(8), .DED_EN(1'b0)) dut_i (
        .clk(clk), .rst(rst),
        .enc_data_i(s_din), .enc_cw_o(s_enc),
        .dec_cw_i(s_cw), .dec_data_o(s_dout),
        .dec_err_o(s_err), .dec_unc_o(s_unc), .dec_pos_o(s_pos)
    );

    // overall-parity instance
    logic [7:0]  d_din;
    logic [12:0] d_enc;
    logic [12:0] d_cw;
    logic [7:0]  d_dout;
    logic        d_err, d_unc;
    logic [3:0]  d_pos;

    ham_codec #(.DATA_W(8), .DED_EN(1'b1)) dut_ded_i (
        .clk(clk), .rst(rst),
        .enc_data_i(d_din), .enc_cw_o(d_enc),
        .dec_cw_i(d_cw), .dec_data_o(d_dout),
        .dec_err_o(d_err), .dec_unc_o(d_unc), .dec_pos_o(d_pos)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [7:0]  din;
        logic [11:0] enc;
        logic [11:0] cw;
        logic [7:0]  dout;
        logic        err;
        logic        unc;
        logic [3:0]  pos;
    } row_t;

    localparam int NROWS = 8;
    localparam row_t ROWS [NROWS] = '{
        '{8'h41, 12'h891, 12'h891, 8'h41, 1'b0, 1'b0, 4'd0},   // R1 R2 R5 clean
        '{8'hFF, 12'hF77, 12'hF67, 8'hFF, 1'b1, 1'b0, 4'd5},   // R6 position 5
        '{8'hA5, 12'hA27, 12'h227, 8'hA5, 1'b1, 1'b0, 4'd12},  // R6 position 12
        '{8'h80, 12'h007, 12'h00F, 8'h80, 1'b1, 1'b0, 4'd4},   // R7 check at 4
        '{8'h01, 12'h888, 12'h889, 8'h01, 1'b1, 1'b0, 4'd1},   // R7 check at 1
        '{8'h3C, 12'h362, 12'h089, 8'h00, 1'b1, 1'b1, 4'd13},  // R8 syndrome 13
        '{8'h00, 12'h000, 12'h3A2, 8'h2C, 1'b1, 1'b1, 4'd15},  // R8 syndrome 15
        '{8'h3C, 12'h362, 12'h366, 8'h3C, 1'b1, 1'b0, 4'd3}    // R6 position 3
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        s_din = 8'hFF; s_cw = 12'hFFF;
        d_din = 8'hFF; d_cw = 13'h1FFF;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R4 reset state with nonzero inputs
        chk("R4 enc", 32'(s_enc), 32'h0);
        chk("R4 data", 32'(s_dout), 32'h0);
        chk("R4 flags", {30'd0, s_err, s_unc}, 32'h0);
        chk("R4 pos", 32'(s_pos), 32'h0);
        chk("R4 ded enc", 32'(d_enc), 32'h0);
        rst = 1'b0;
        s_din = 8'h00; s_cw = 12'h000;
        @(negedge clk);

        // R3 latency probe: old value before edge, new after it
        s_din = 8'h41;
        #2;
        chk("R3 before edge", 32'(s_enc), 32'h000);
        @(negedge clk);
        chk("R3 after edge", 32'(s_enc), 32'h891);

        for (int i = 0; i < NROWS; i++) begin
            s_din = ROWS[i].din;
            s_cw  = ROWS[i].cw;
            @(negedge clk);
            chk($sformatf("R1/R2 row %0d enc", i), 32'(s_enc), 32'(ROWS[i].enc));
            chk($sformatf("row %0d data", i), 32'(s_dout), 32'(ROWS[i].dout));
            chk($sformatf("row %0d err", i), 32'(s_err), 32'(ROWS[i].err));
            chk($sformatf("row %0d unc", i), 32'(s_unc), 32'(ROWS[i].unc));
            chk($sformatf("row %0d pos", i), 32'(s_pos), 32'(ROWS[i].pos));
        end

        // R9 overall parity: encode and lone parity-bit flip
        d_din = 8'h80; d_cw = 13'h0007;
        @(negedge clk);
        chk("R9 enc 0x80", 32'(d_enc), 32'h1007);
        chk("R9 data", 32'(d_dout), 32'h80);
        chk("R9 flags", {30'd0, d_err, d_unc}, 32'h2);
        chk("R9 pos", 32'(d_pos), 32'd13);

        // R9 single check-bit flip still repaired
        d_din = 8'h41; d_cw = 13'h100F;
        @(negedge clk);
        chk("R9 enc 0x41", 32'(d_enc), 32'h0891);
        chk("R9 single data", 32'(d_dout), 32'h80);
        chk("R9 single flags", {30'd0, d_err, d_unc}, 32'h2);
        chk("R9 single pos", 32'(d_pos), 32'd4);

        // R5 clean word on the parity build
        d_cw = 13'h0891;
        @(negedge clk);
        chk("R5 ded data", 32'(d_dout), 32'h41);
        chk("R5 ded flags", {30'd0, d_err, d_unc}, 32'h0);

        // R10 double error: positions 1 and 2 of 0x0891
        d_cw = 13'h0892;
        @(negedge clk);
        chk("R10 data", 32'(d_dout), 32'h41);
        chk("R10 flags", {30'd0, d_err, d_unc}, 32'h3);
        chk("R10 pos", 32'(d_pos), 32'd3);

        // R4 reset in mid-run
        s_din = 8'hA5; s_cw = 12'h227;
        rst = 1'b1;
        @(negedge clk);
        chk("R4 mid enc", 32'(s_enc), 32'h0);
        chk("R4 mid data", 32'(s_dout), 32'h0);
        chk("R4 mid flags", {30'd0, s_err, s_unc}, 32'h0);
        chk("R4 mid pos", 32'(s_pos), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 after reset", 32'(s_dout), 32'hA5);

        finish_run();
    end

endmodule